// File: doc/BRIEF.md
# Four-Way Low-Order Interleaved Memory Dispatcher

This block sits between a single request bus and four independent memory banks. Each request carries an address, write data and a write flag. The two lowest address bits pick the bank, and the remaining upper bits form the word address inside that bank. Bank k therefore holds every word whose address leaves remainder k when divided by four. A bank needs `MEM_CYC` bus cycles to finish an access. The bus can still hand over one request per cycle, because consecutive addresses fall into different banks and their accesses overlap in time.

The request port uses a valid/ready handshake. Ready drops only when the addressed bank is still inside its memory cycle, or when it still holds a read result that has not yet gone out. Read results come back on one shared response path. They leave in the order the reads were accepted, whatever order the banks finish in. A small queue of bank indices enforces that order. A write is accepted, occupies its bank for a full memory cycle, and produces no response.

Top module: `ilv_dispatch`

## Requirements
- R1: An accepted request raises exactly one bit of `mod_en`, the bit whose index equals `req_addr[1:0]`. No bit of `mod_en` is high in a cycle without a handshake.
- R2: In the cycle a request is accepted, `mod_addr` equals `req_addr[AW-1:2]`. `mod_we` and `mod_wdata` carry the request's write flag and data.
- R3: Requests to four successive addresses, each to a free bank, are accepted in four successive cycles, with no stall cycle.
- R4: A bank accepts a new request no sooner than `MEM_CYC` cycles after its previous one. With an idle bus and fixed-latency banks, a request is accepted in the earliest cycle that meets both this rule and the one-request-per-cycle bus limit.
- R5: Each read response carries the data last written to that address, or the initial content if the address was never written. Responses appear in the order the reads were accepted.
- R6: With banks that raise `mod_rvalid` in the `MEM_CYC-1`-th cycle after `mod_en`, each read response is valid exactly `MEM_CYC` cycles after its handshake cycle.
- R7: A write never produces a response, and it still holds its bank busy for `MEM_CYC` cycles.
- R8: After reset, `rsp_valid` is low, `mod_en` is zero, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Addressed bank can take the request |
| req_addr | input | AW | Word address; bits [1:0] select the bank |
| req_wdata | input | DW | Write data |
| req_we | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Read result valid (one cycle per read) |
| rsp_data | output | DW | Read result |
| mod_en | output | 4 | Per-bank access strobe |
| mod_we | output | 1 | Write flag shared by all banks |
| mod_addr | output | AW-2 | Word address inside the bank |
| mod_wdata | output | DW | Write data shared by all banks |
| mod_rvalid | input | 4 | Per-bank read data valid |
| mod_rdata | input | 4*DW | Per-bank read data, bank k at bits [k*DW +: DW] |

## Verification
A wrong busy counter shows up at the request handshake, in the very cycle it goes wrong. A bank is either released one cycle early, which is a strobe closer than `MEM_CYC` cycles to the previous one, or held one cycle too long, which is a handshake later than the arithmetic earliest cycle. A corrupted order queue or result slot shows on the response path when the affected read reaches the head. It appears as wrong data, a response in the wrong cycle, or a missing or extra response, all within `MEM_CYC` cycles of the handshake. Sweeps at strides 1 to 4, same-bank write bursts and a long pseudo-random mix compare every handshake cycle and every response against these bench-computed values.

// File: rtl/ilv_dispatch.sv
module ilv_dispatch #(
  parameter int AW      = 8,
  parameter int DW      = 16,
  parameter int MEM_CYC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic            req_we,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_data,
  output logic [3:0]      mod_en,
  output logic            mod_we,
  output logic [AW-3:0]   mod_addr,
  output logic [DW-1:0]   mod_wdata,
  input  logic [3:0]      mod_rvalid,
  input  logic [4*DW-1:0] mod_rdata
);
  localparam int NB = 4;
  localparam int BW = 2;
  localparam int CW = (MEM_CYC > 2) ? $clog2(MEM_CYC) : 1;

  logic [NB-1:0][CW-1:0] busy_cnt;
  logic [NB-1:0][DW-1:0] slot;
  logic [NB-1:0][BW-1:0] order_q;
  logic [NB-1:0]         pend, full, avail, freed;
  logic [BW-1:0]         wp, rp;
  logic [BW:0]           qn;

  wire [BW-1:0] sel  = req_addr[BW-1:0];
  wire [BW-1:0] head = order_q[rp];
  wire          fire = req_valid & req_ready;
  wire          push = fire & ~req_we;

  assign rsp_valid = (qn != '0) & full[head];
  assign rsp_data  = slot[head];
  assign freed     = rsp_valid ? (NB'(1) << head) : '0;

  always_comb
    for (int k = 0; k < NB; k++)
      avail[k] = (busy_cnt[k] == '0) && (!pend[k] || freed[k]);

  assign req_ready = avail[sel];
  assign mod_en    = fire ? (NB'(1) << sel) : '0;
  assign mod_we    = req_we;
  assign mod_addr  = req_addr[AW-1:BW];
  assign mod_wdata = req_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_cnt <= '0;
      pend     <= '0;
      full     <= '0;
    end else begin
      for (int k = 0; k < NB; k++) begin
        if (mod_en[k])               busy_cnt[k] <= CW'(MEM_CYC - 1);
        else if (busy_cnt[k] != '0)  busy_cnt[k] <= busy_cnt[k] - CW'(1);
        if (mod_en[k] && !req_we)    pend[k] <= 1'b1;
        else if (freed[k])           pend[k] <= 1'b0;
        if (mod_rvalid[k])           full[k] <= 1'b1;
        else if (freed[k])           full[k] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk)
    for (int k = 0; k < NB; k++)
      if (mod_rvalid[k]) slot[k] <= mod_rdata[k*DW +: DW];

  always_ff @(posedge clk)
    if (push) order_q[wp] <= sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      qn <= '0;
    end else begin
      if (push)      wp <= wp + BW'(1);
      if (rsp_valid) rp <= rp + BW'(1);
      if (push && !rsp_valid)      qn <= qn + (BW+1)'(1);
      else if (!push && rsp_valid) qn <= qn - (BW+1)'(1);
    end
  end
endmodule

// File: rtl/ilv_dispatch_chk.sv
module ilv_dispatch_chk #(
  parameter int MEM_CYC = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_we,
  input logic       rsp_valid,
  input logic [3:0] mod_en
);
  logic [3:0][15:0] gap;
  logic [3:0]       rd_out;
  wire rd_fire = req_valid && req_ready && !req_we;
  wire wr_fire = req_valid && req_ready && req_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) gap[k] <= 16'(MEM_CYC);
      rd_out <= '0;
    end else begin
      for (int k = 0; k < 4; k++)
        if (mod_en[k])                    gap[k] <= 16'd1;
        else if (gap[k] < 16'(MEM_CYC))   gap[k] <= gap[k] + 16'd1;
      if (rd_fire && !rsp_valid)      rd_out <= rd_out + 4'd1;
      else if (!rd_fire && rsp_valid) rd_out <= rd_out - 4'd1;
    end
  end

  for (genvar k = 0; k < 4; k++) begin : g_bank
    p_bank_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mod_en[k] |-> gap[k] >= 16'(MEM_CYC));
  end

  p_single_bank_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mod_en));

  p_rsp_backed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rd_out != 4'd0);

  p_rd_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_out <= 4'd4);

  p_wr_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && rd_out == 4'd0 && !rsp_valid) |=> !rsp_valid);
endmodule

bind ilv_dispatch ilv_dispatch_chk #(.MEM_CYC(MEM_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_we(req_we), .rsp_valid(rsp_valid), .mod_en(mod_en)
);

// File: tb/tb_ilv_dispatch.sv
module tb_ilv_dispatch;
  localparam int M  = 4;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0, req_we = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, mod_we;
  logic [DW-1:0] rsp_data, mod_wdata;
  logic [3:0] mod_en, mod_rvalid;
  logic [AW-3:0] mod_addr;
  logic [4*DW-1:0] mod_rdata;

  always #10 clk = ~clk;

  ilv_dispatch #(.AW(AW), .DW(DW), .MEM_CYC(M)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_we(req_we),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mod_en(mod_en), .mod_we(mod_we),
    .mod_addr(mod_addr), .mod_wdata(mod_wdata), .mod_rvalid(mod_rvalid),
    .mod_rdata(mod_rdata));

  int checks = 0, fails = 0, cyc = 0;
  logic [DW-1:0] bmem [4][64];
  logic [DW-1:0] refm [256];
  int rcnt [4];
  logic [DW-1:0] rdd [4];
  int eq_data [4096];
  int eq_cyc  [4096];
  int eq_w = 0, eq_r = 0, rd_total = 0;
  int prev_hs = -100;
  int lastb [4] = '{-100, -100, -100, -100};

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk)
    for (int k = 0; k < 4; k++) begin
      if (mod_en[k]) begin
        if (mod_we) bmem[k][mod_addr] <= mod_wdata;
        else begin rcnt[k] <= M - 1; rdd[k] <= bmem[k][mod_addr]; end
      end else if (rcnt[k] != 0) rcnt[k] <= rcnt[k] - 1;
    end

  always_comb
    for (int k = 0; k < 4; k++) begin
      mod_rvalid[k] = (rcnt[k] == 1);
      mod_rdata[k*DW +: DW] = rdd[k];
    end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk)
    if (rst_n && rsp_valid) begin
      if (eq_r >= eq_w) check(0, "R7 response with no read outstanding", 1, 0);
      else begin
        check(int'(rsp_data) == eq_data[eq_r], "R5 read data/order", int'(rsp_data), eq_data[eq_r]);
        check(cyc == eq_cyc[eq_r], "R6 response cycle", cyc, eq_cyc[eq_r]);
        eq_r++;
      end
    end

  task automatic issue(logic [AW-1:0] a, logic we, logic [DW-1:0] wd, string tag);
    int present, exp, hs, b;
    b = int'(a[1:0]);
    present = cyc;
    req_valid = 1; req_addr = a; req_we = we; req_wdata = wd;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    hs = cyc;
    exp = present;
    if (prev_hs + 1 > exp) exp = prev_hs + 1;
    if (lastb[b] + M > exp) exp = lastb[b] + M;
    check(hs == exp, tag, hs, exp);
    check(mod_en == (4'b1 << a[1:0]), "R1 bank strobe", int'(mod_en), 1 << b);
    check(mod_addr == a[AW-1:2], "R2 bank address", int'(mod_addr), int'(a[AW-1:2]));
    if (we) check(mod_we && mod_wdata == wd, "R2 write data", int'(mod_wdata), int'(wd));
    prev_hs = hs;
    lastb[b] = hs;
    if (we) refm[a] = wd;
    else begin
      eq_data[eq_w] = int'(refm[a]);
      eq_cyc[eq_w] = hs + M;
      eq_w++;
      rd_total++;
    end
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    summary();
    $finish;
  end

  initial begin
    logic [15:0] lf;
    for (int a = 0; a < 256; a++) begin
      refm[a] = 16'hA000 ^ 16'(a * 37);
      bmem[a % 4][a / 4] = 16'hA000 ^ 16'(a * 37);
    end
    for (int k = 0; k < 4; k++) begin rcnt[k] = 0; rdd[k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    check(req_ready == 1'b1, "R8 ready after reset", int'(req_ready), 1);
    check(rsp_valid == 1'b0, "R8 no response after reset", int'(rsp_valid), 0);
    check(mod_en == 4'b0, "R8 no strobe after reset", int'(mod_en), 0);
    @(negedge clk);

    for (int s = 1; s <= 4; s++) begin
      for (int i = 0; i < 16; i++)
        issue(AW'(i * s + 3), 1'b0, '0, (s == 1) ? "R3 no stall handshake" : "R4 handshake cycle");
      req_valid = 0;
      repeat (8) @(negedge clk);
    end

    for (int i = 0; i < 16; i++) issue(AW'(i * 4 + 1), 1'b1, DW'(16'h5000 + i), "R7 write occupies bank");
    for (int i = 0; i < 16; i++) issue(AW'(i + 100), 1'b1, DW'(16'h6100 + i), "R7 write handshake cycle");
    req_valid = 0;
    repeat (8) @(negedge clk);
    check(eq_r == eq_w, "R7 writes gave no response", eq_r, eq_w);
    for (int i = 0; i < 16; i++) issue(AW'(i * 4 + 1), 1'b0, '0, "R4 readback handshake");
    for (int i = 0; i < 16; i++) issue(AW'(i + 100), 1'b0, '0, "R3 readback handshake");
    req_valid = 0;
    repeat (3) @(negedge clk);

    lf = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      issue(lf[7:0], lf[11] & lf[3], lf ^ 16'h3C3C, "R4 mixed handshake cycle");
      if (lf[14:13] == 2'b11) begin
        req_valid = 0;
        @(negedge clk);
      end
    end
    req_valid = 0;
    repeat (4 * M + 4) @(negedge clk);
    check(eq_r == eq_w, "R5 every read answered", eq_r, eq_w);
    check(eq_w == rd_total, "R7 only reads queued", eq_w, rd_total);
    check(rsp_valid == 1'b0, "R7 idle response path", int'(rsp_valid), 0);
    summary();
    $finish;
  end
endmodule